// File: doc/BRIEF.md
# Bit-Serial FIR Decimation Accumulator

Each pixel carries this decimator for its first-order delta-sigma modulator. A shared controller sends every pixel the same stream of FIR filter coefficients, one bit per clock. Inside the pixel, one AND gate multiplies the current coefficient bit by the modulator's one-bit output. A single full adder with a carry flip-flop then folds that product into a 19-bit running total. The total is kept in a circular shift register and turns once for every coefficient.

A frame-start strobe clears the total. A frame-end strobe copies the total into a parallel output register, which is the decimated sample for that frame, and raises a one-cycle valid flag. The filter taps are chosen entirely by the coefficients the controller sends. The pixel only decides, from its own modulator bit, whether each coefficient is added or skipped.

With a 1 MHz serial clock and a 50 Hz frame rate, a frame holds about 1050 coefficient words. The sum wraps modulo 2^19.

Top module: `serial_fir_decimator`

## Requirements
- R1: At each frame end, `sum_o` equals the sum, modulo 2^19, of every coefficient in that frame whose sampled modulator bit was 1. Overflow wraps and raises no flag.
- R2: Each coefficient is 19 bits long and arrives least significant bit first on `coef_bit_i`. It occupies 19 consecutive clocks, and the first of these clocks has `word_start_i` high.
- R3: The modulator bit is taken from `mod_bit_i` only in the `word_start_i` cycle. Its value in the other 18 cycles of the word has no effect.
- R4: A coefficient whose sampled modulator bit is 0 leaves the total unchanged.
- R5: In cycles outside a word, neither `coef_bit_i` nor `mod_bit_i` changes the total.
- R6: The carry is cleared at every word start, so a carry out of bit 18 of one word never reaches bit 0 of the next word.
- R7: A `frame_start_i` cycle clears the total synchronously and cancels any word in progress.
- R8: A `frame_end_i` cycle loads the total into `sum_o`. In the next cycle `sum_valid_o` is high for exactly one cycle.
- R9: `sum_o` keeps its value in every cycle that does not follow a `frame_end_i` cycle.
- R10: After synchronous reset, `sum_o` is 0, `sum_valid_o` is 0 and the total is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Clears the running total |
| frame_end_i | input | 1 | Captures the total into the output register |
| word_start_i | input | 1 | Marks bit 0 of a coefficient |
| coef_bit_i | input | 1 | Broadcast coefficient bit, LSB first |
| mod_bit_i | input | 1 | Modulator output bit |
| sum_o | output | 19 | Decimated sample of the last frame |
| sum_valid_o | output | 1 | One-cycle pulse when `sum_o` is updated |

## Verification
The bench runs several kinds of frame:
- Frames with hand-picked coefficients confirm the basic addition.
- One frame where every modulator bit is 0 separates gating from plain accumulation.
- A frame that carries out of bit 18 and then adds a small word shows whether the carry leaks across the word boundary (the sum would come out 3 instead of 2).

During each word, the modulator bit is driven to its inverse after the start cycle, and idle gaps carry toggling inputs. These two patterns separate a correctly held sample from one taken every cycle. A pseudo-random sweep covers varying word counts, gaps and gating, and is checked against a modulo-2^19 sum computed in the bench.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int ACC_W = 19;

    typedef struct packed {
        logic a;
        logic b;
        logic cin;
    } fa_in_t;

    typedef struct packed {
        logic cout;
        logic s;
    } fa_out_t;

    function automatic fa_out_t full_add(fa_in_t x);
        fa_out_t r;
        r.s    = x.a ^ x.b ^ x.cin;
        r.cout = (x.a & x.b) | (x.a & x.cin) | (x.b & x.cin);
        return r;
    endfunction

endpackage

// File: rtl/sfd_word_ctrl.sv
module sfd_word_ctrl #(
    parameter int W = sfd_pkg::ACC_W
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start_i,
    input  logic word_start_i,
    input  logic coef_bit_i,
    input  logic mod_bit_i,
    output logic shift_en_o,
    output logic carry_clr_o,
    output logic prod_bit_o
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             held_q;
    logic             busy;
    logic             gate;

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || frame_start_i) begin
            cnt_q <= '0;
        end else if (word_start_i) begin
            cnt_q <= CNT_W'(1);
        end else if (busy) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else if (word_start_i) begin
            held_q <= mod_bit_i;
        end
    end

    always_comb begin
        gate        = word_start_i ? mod_bit_i : held_q;
        shift_en_o  = !frame_start_i && (word_start_i || busy);
        carry_clr_o = word_start_i;
        prod_bit_o  = shift_en_o && coef_bit_i && gate;
    end

    // R2: the bit position within a word never exceeds the last index
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R3: the sampled modulator bit only changes at a word start
    p_hold_mod_r3: assert property (@(posedge clk) disable iff (rst)
        !word_start_i |=> $stable(held_q));

endmodule

// File: rtl/sfd_serial_acc.sv
module sfd_serial_acc #(
    parameter int W = sfd_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         shift_en_i,
    input  logic         carry_clr_i,
    input  logic         prod_bit_i,
    output logic [W-1:0] acc_o
);
    import sfd_pkg::*;

    logic [W-1:0] acc_q;
    logic         carry_q;
    fa_in_t       fa_in;
    fa_out_t      fa_out;

    always_comb begin
        fa_in.a   = acc_q[0];
        fa_in.b   = prod_bit_i;
        fa_in.cin = carry_clr_i ? 1'b0 : carry_q;
        fa_out    = full_add(fa_in);
    end

    generate
        if (W > 1) begin : g_ring
            always_ff @(posedge clk) begin
                if (rst || clear_i) begin
                    acc_q   <= '0;
                    carry_q <= 1'b0;
                end else if (shift_en_i) begin
                    acc_q   <= {fa_out.s, acc_q[W-1:1]};
                    carry_q <= fa_out.cout;
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst || clear_i) begin
                    acc_q   <= '0;
                    carry_q <= 1'b0;
                end else if (shift_en_i) begin
                    acc_q   <= fa_out.s;
                    carry_q <= fa_out.cout;
                end
            end
        end
    endgenerate

    assign acc_o = acc_q;

    // R7: a frame start empties the total in the next cycle
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> acc_q == '0);

    // R5: no shift, no change of the total
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!shift_en_i && !clear_i) |=> $stable(acc_q));

    // R6: a word-start bit with a zero product cannot produce a carry
    p_carry_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (carry_clr_i && shift_en_i && !clear_i && !prod_bit_i) |=> !carry_q);

endmodule

// File: rtl/sfd_out_reg.sv
module sfd_out_reg #(
    parameter int W = sfd_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_i,
    input  logic [W-1:0] acc_i,
    output logic [W-1:0] sum_o,
    output logic         valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= capture_i;
            if (capture_i) begin
                sum_o <= acc_i;
            end
        end
    end

    // R8: a capture is followed by a valid pulse
    p_valid_r8: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> valid_o);

    // R8: no valid without a preceding capture
    p_valid_only_r8: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> !valid_o);

    // R9: the output word holds between captures
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> $stable(sum_o));

endmodule

// File: rtl/serial_fir_decimator.sv
module serial_fir_decimator #(
    parameter int W = sfd_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_start_i,
    input  logic         frame_end_i,
    input  logic         word_start_i,
    input  logic         coef_bit_i,
    input  logic         mod_bit_i,
    output logic [W-1:0] sum_o,
    output logic         sum_valid_o
);
    logic         shift_en;
    logic         carry_clr;
    logic         prod_bit;
    logic [W-1:0] acc;

    sfd_word_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .frame_start_i(frame_start_i),
        .word_start_i (word_start_i),
        .coef_bit_i   (coef_bit_i),
        .mod_bit_i    (mod_bit_i),
        .shift_en_o   (shift_en),
        .carry_clr_o  (carry_clr),
        .prod_bit_o   (prod_bit)
    );

    sfd_serial_acc #(.W(W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (frame_start_i),
        .shift_en_i (shift_en),
        .carry_clr_i(carry_clr),
        .prod_bit_i (prod_bit),
        .acc_o      (acc)
    );

    sfd_out_reg #(.W(W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .capture_i(frame_end_i),
        .acc_i    (acc),
        .sum_o    (sum_o),
        .valid_o  (sum_valid_o)
    );

    // R4: a word gated off never feeds a one into the adder
    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (word_start_i && !mod_bit_i) |-> !prod_bit);

endmodule

// File: tb/serial_fir_decimator_tb_top.sv
`timescale 1ns/1ps
module serial_fir_decimator_tb_top;
    localparam int W = 19;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_start_i = 1'b0;
    logic         frame_end_i = 1'b0;
    logic         word_start_i = 1'b0;
    logic         coef_bit_i = 1'b0;
    logic         mod_bit_i = 1'b0;
    logic [W-1:0] sum_o;
    logic         sum_valid_o;

    int           n_checks = 0;
    int           n_errors = 0;
    logic [W-1:0] ref_sum = '0;
    logic [31:0]  lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    serial_fir_decimator #(.W(W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .frame_start_i(frame_start_i),
        .frame_end_i  (frame_end_i),
        .word_start_i (word_start_i),
        .coef_bit_i   (coef_bit_i),
        .mod_bit_i    (mod_bit_i),
        .sum_o        (sum_o),
        .sum_valid_o  (sum_valid_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Drive one 19-bit coefficient, LSB first (R2). After the start cycle the
    // modulator bit is inverted: it must be ignored there (R3).
    task automatic send_word(input logic [W-1:0] c, input bit m);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            word_start_i = (i == 0);
            coef_bit_i   = c[i];
            mod_bit_i    = (i == 0) ? m : ~m;
        end
        if (m) ref_sum = ref_sum + c;
    endtask

    // Cycles outside any word with toggling inputs (R5)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            word_start_i = 1'b0;
            coef_bit_i   = ~coef_bit_i;
            mod_bit_i    = ~mod_bit_i;
        end
    endtask

    task automatic start_frame();
        @(negedge clk);
        word_start_i  = 1'b0;
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
        ref_sum = '0;
    endtask

    task automatic end_frame(input string req);
        @(negedge clk);
        word_start_i = 1'b0;
        frame_end_i  = 1'b1;
        @(negedge clk);
        frame_end_i = 1'b0;
        chk(sum_valid_o == 1'b1, "R8 valid pulse", sum_valid_o, 1);
        chk(sum_o == ref_sum, req, sum_o, ref_sum);
        @(negedge clk);
        chk(sum_valid_o == 1'b0, "R8 single pulse", sum_valid_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk(sum_o == '0, "R10 sum", sum_o, 0);
        chk(sum_valid_o == 1'b0, "R10 valid", sum_valid_o, 0);
        end_frame("R10 total empty");

        // R1 R2 R3 R4: basic sums, one gated-off word
        start_frame();
        send_word(19'd3, 1'b1);
        send_word(19'h1000, 1'b0);
        send_word(19'd5, 1'b1);
        send_word(19'd7, 1'b1);
        end_frame("R1 basic sum");

        // R4: all gated off
        start_frame();
        send_word(19'h7FFFF, 1'b0);
        send_word(19'h12345, 1'b0);
        end_frame("R4 gated off");

        // R9: output holds through a following frame
        start_frame();
        send_word(19'd100, 1'b1);
        chk(sum_o == '0, "R9 hold", sum_o, 0);
        chk(sum_valid_o == 1'b0, "R9 no valid", sum_valid_o, 0);
        end_frame("R9 new capture");

        // R6 and R1 wrap: carry out of bit 18 must not reach the next word
        start_frame();
        send_word(19'h7FFFF, 1'b1);
        send_word(19'd1, 1'b1);
        send_word(19'd2, 1'b1);
        end_frame("R6 carry cleared, R1 wrap");

        // R5: idle gaps with toggling inputs
        start_frame();
        send_word(19'd9, 1'b1);
        idle(7);
        send_word(19'd4, 1'b1);
        idle(3);
        end_frame("R5 idle gaps");

        // R7: frame start clears a partial total
        start_frame();
        send_word(19'd50, 1'b1);
        start_frame();
        send_word(19'd6, 1'b1);
        end_frame("R7 clear");

        // R1: pseudo-random sweep
        for (int f = 0; f < 24; f++) begin
            start_frame();
            for (int w = 0; w < 1 + (f % 6); w++) begin
                logic [31:0] r;
                r = next_rand();
                send_word(r[W-1:0], r[31]);
                idle(f % 3);
            end
            end_frame("R1 sweep");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule